// File: doc/BRIEF.md
# Lockable Clock Configuration Register Bank

This block holds the configuration bits that steer a microcontroller's clock controller. Software reaches it through a byte-wide bus with one write strobe per cycle and a combinational read port. There are four registers: a peripheral clock select, a processor mode register holding the wait-select bit and two lock bits, a clock control register holding the lockable clock bits, and a protect register. Each of the first three registers accepts writes only while its own enable bit in the protect register is set.

The two lock bits are one-way. Software can set them but never clear them. While the system-clock lock is set, the lockable clock control bits are frozen and wait-instruction requests are refused. While the watchdog-source lock is set, the watchdog counts from the on-chip oscillator, that oscillator is kept running, the watchdog keeps running in idle states, and any attempt to request stop mode is dropped. A write that is blocked leaves the register as it was and raises no error output.

Register addresses: 0 = peripheral select, 1 = mode, 2 = clock control, 3 = protect.

Top module: `clkcfg_bank`

## Requirements
- R1: After reset, the registers read as follows: peripheral select 0x03, mode 0x00, clock control 0x00, protect 0x00. With no lock set, `waitGrant` follows `waitReq`.
- R2: A write to peripheral select takes effect only while protect bit 0 is 1. Bit 0 drives `timerClkFull` and bit 1 drives `serClkFull`; a 1 selects the undivided clock and a 0 selects the clock divided by two. Bits 7..2 read 0.
- R3: A write to the mode register takes effect only while protect bit 1 is 1. Bits 7..3 read 0.
- R4: A write to clock control takes effect only while protect bit 2 is 1. The fields are: bit0 `mainClkStop`, bit1 `cpuClkSel`, bit2 `stopReq`, bit3 `oscStopDetEn`, bit4 `pllEn`, bits 6..5 `pllMul`, bit7 `subClkOn`.
- R5: Mode bit 1 (system-clock lock) and mode bit 2 (watchdog-source lock) are sticky. Writing 0 does not clear them; only reset does.
- R6: While the system-clock lock is 1, writes leave clock control bits 6..0 unchanged. Bit 7 stays writable.
- R7: While the watchdog-source lock is 1, `wdtSrcOsc`, `ocoEnable` and `wdtRunInIdle` are 1, and a write of 1 to clock control bit 2 leaves it at 0.
- R8: Mode bit 0 (wait select, driving `sfrOneWait`; 1 = one wait, 0 = two waits) changes only when clock control bit 4 (PLL enable) is 0 at the time of the write.
- R9: `waitGrant` equals `waitReq` while the system-clock lock is 0, and is 0 while the lock is 1.
- R10: The protect register accepts writes at any time. Its bits 2..0 are stored and its bits 7..3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| waitReq | input | 1 | Wait-instruction request |
| waitGrant | output | 1 | Request accepted |
| timerClkFull | output | 1 | Timer clock undivided |
| serClkFull | output | 1 | Serial clock undivided |
| sfrOneWait | output | 1 | One SFR wait state while the PLL runs |
| mainClkStop | output | 1 | Stop the main clock |
| cpuClkSel | output | 1 | CPU clock source select |
| stopReq | output | 1 | Stop-mode entry request |
| oscStopDetEn | output | 1 | Oscillation-stop detect enable |
| pllEn | output | 1 | PLL enable |
| pllMul | output | 2 | PLL multiplier select |
| subClkOn | output | 1 | Sub clock enable (never locked) |
| wdtSrcOsc | output | 1 | Watchdog counts from the on-chip oscillator |
| ocoEnable | output | 1 | On-chip oscillator enable |
| wdtRunInIdle | output | 1 | Watchdog keeps running in wait and hold states |

## Verification
Each register takes its new value at the rising edge on which `busWe` is sampled high. The register read and the control outputs derived from it therefore show the new value one edge after the write, while `waitGrant` and `busRdata` respond combinationally within the same cycle. The bench drives each write on a falling edge and releases it on the next falling edge, so the capturing edge has passed before anything is compared. It then sets the read address and samples a moment later, still away from any rising edge. This applies equally to blocked writes: a register that should be unchanged is read back after the edge that would otherwise have changed it.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int PROT_W = 3;
  localparam int MUL_W  = 2;

  localparam logic [ADDR_W-1:0] A_PSEL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLK  = 2'd2;
  localparam logic [ADDR_W-1:0] A_PROT = 2'd3;

  localparam logic [1:0] PSEL_RST = 2'b11;

  // bit positions inside the clock control register
  localparam int CB_STOP = 2;
  localparam int CB_PLL  = 4;
  localparam int CB_FREE = DATA_W - 1;

  typedef struct packed {
    logic wrPsel;
    logic wrMode;
    logic waitOk;
    logic wrClkOpen;
    logic wrClkFree;
    logic stopBlock;
    logic wrProt;
  } strobe_t;
endpackage

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PROT_W-1:0] protQ,
  input  logic              sysLock,
  input  logic              wdtLock,
  input  logic              pllOn,
  input  logic              waitReq,
  output strobe_t           stb,
  output logic              waitGrant
);
  always_comb begin
    stb           = '0;
    stb.wrPsel    = busWe && (busAddr == A_PSEL) && protQ[0];
    stb.wrMode    = busWe && (busAddr == A_MODE) && protQ[1];
    stb.waitOk    = !pllOn;
    stb.wrClkFree = busWe && (busAddr == A_CLK) && protQ[2];
    stb.wrClkOpen = stb.wrClkFree && !sysLock;
    stb.stopBlock = wdtLock;
    stb.wrProt    = busWe && (busAddr == A_PROT);
  end

  assign waitGrant = waitReq && !sysLock;
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        pselQ,
  output logic              waitSelQ,
  output logic              sysLockQ,
  output logic              wdtLockQ,
  output logic [DATA_W-1:0] clkQ,
  output logic [PROT_W-1:0] protQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pselQ    <= PSEL_RST;
      waitSelQ <= 1'b0;
      sysLockQ <= 1'b0;
      wdtLockQ <= 1'b0;
      clkQ     <= '0;
      protQ    <= '0;
    end else begin
      if (stb.wrPsel) pselQ <= busWdata[1:0];
      if (stb.wrMode) begin
        if (stb.waitOk) waitSelQ <= busWdata[0];
        sysLockQ <= sysLockQ | busWdata[1];
        wdtLockQ <= wdtLockQ | busWdata[2];
      end
      if (stb.wrClkFree) clkQ[CB_FREE] <= busWdata[CB_FREE];
      if (stb.wrClkOpen) begin
        clkQ[CB_FREE-1:0] <= busWdata[CB_FREE-1:0];
        clkQ[CB_STOP]     <= busWdata[CB_STOP] & ~stb.stopBlock;
      end
      if (stb.wrProt) protQ <= busWdata[PROT_W-1:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      A_PSEL:  busRdata = DATA_W'(pselQ);
      A_MODE:  busRdata = DATA_W'({wdtLockQ, sysLockQ, waitSelQ});
      A_CLK:   busRdata = clkQ;
      default: busRdata = DATA_W'(protQ);
    endcase
  end
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              waitReq,
  output logic              waitGrant,
  output logic              timerClkFull,
  output logic              serClkFull,
  output logic              sfrOneWait,
  output logic              mainClkStop,
  output logic              cpuClkSel,
  output logic              stopReq,
  output logic              oscStopDetEn,
  output logic              pllEn,
  output logic [MUL_W-1:0]  pllMul,
  output logic              subClkOn,
  output logic              wdtSrcOsc,
  output logic              ocoEnable,
  output logic              wdtRunInIdle
);
  strobe_t           stb;
  logic [1:0]        pselQ;
  logic              waitSelQ, sysLockQ, wdtLockQ;
  logic [DATA_W-1:0] clkQ;
  logic [PROT_W-1:0] protQ;

  clkcfg_ctrl u_ctrl (
    .busWe(busWe), .busAddr(busAddr), .protQ(protQ),
    .sysLock(sysLockQ), .wdtLock(wdtLockQ), .pllOn(clkQ[CB_PLL]),
    .waitReq(waitReq), .stb(stb), .waitGrant(waitGrant)
  );

  clkcfg_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pselQ(pselQ),
    .waitSelQ(waitSelQ), .sysLockQ(sysLockQ), .wdtLockQ(wdtLockQ),
    .clkQ(clkQ), .protQ(protQ)
  );

  assign timerClkFull = pselQ[0];
  assign serClkFull   = pselQ[1];
  assign sfrOneWait   = waitSelQ;
  assign mainClkStop  = clkQ[0];
  assign cpuClkSel    = clkQ[1];
  assign stopReq      = clkQ[CB_STOP];
  assign oscStopDetEn = clkQ[3];
  assign pllEn        = clkQ[CB_PLL];
  assign pllMul       = clkQ[6:5];
  assign subClkOn     = clkQ[CB_FREE];
  assign wdtSrcOsc    = wdtLockQ;
  assign ocoEnable    = wdtLockQ;
  assign wdtRunInIdle = wdtLockQ;
endmodule

// File: rtl/clkcfg_bank_chk.sv
module clkcfg_bank_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWe,
  input logic [1:0] busAddr,
  input logic [2:0] protQ,
  input logic       sysLock,
  input logic       wdtLock,
  input logic       waitGrant,
  input logic       timerClkFull,
  input logic       serClkFull,
  input logic       sfrOneWait,
  input logic [6:0] lockedBits,
  input logic       pllEn,
  input logic       wdtSrcOsc,
  input logic       ocoEnable,
  input logic       wdtRunInIdle
);
  a_r5_sys_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sysLock |=> sysLock);
  a_r5_wdt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdtLock |=> wdtLock);
  a_r6_lock_freeze: assert property (@(posedge clk) disable iff (!rstN)
    sysLock |=> $stable(lockedBits));
  a_r7_wdt_source: assert property (@(posedge clk) disable iff (!rstN)
    wdtLock |-> (wdtSrcOsc && ocoEnable && wdtRunInIdle));
  a_r9_wait_reject: assert property (@(posedge clk) disable iff (!rstN)
    sysLock |-> !waitGrant);
  a_r2_psel_guard: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd0 && !protQ[0]) |=> $stable({timerClkFull, serClkFull}));
  a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |=> $stable(sfrOneWait));
endmodule

bind clkcfg_bank clkcfg_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .protQ(protQ),
  .sysLock(sysLockQ), .wdtLock(wdtLockQ), .waitGrant(waitGrant),
  .timerClkFull(timerClkFull), .serClkFull(serClkFull), .sfrOneWait(sfrOneWait),
  .lockedBits(clkQ[6:0]), .pllEn(pllEn), .wdtSrcOsc(wdtSrcOsc),
  .ocoEnable(ocoEnable), .wdtRunInIdle(wdtRunInIdle)
);

// File: tb/clkcfg_bank_test.sv
module clkcfg_bank_test;
  logic clk = 0, rstN = 0, busWe = 0, waitReq = 0;
  logic [1:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic waitGrant, timerClkFull, serClkFull, sfrOneWait, mainClkStop, cpuClkSel;
  logic stopReq, oscStopDetEn, pllEn, subClkOn, wdtSrcOsc, ocoEnable, wdtRunInIdle;
  logic [1:0] pllMul;
  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  clkcfg_bank uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rdChk(string req, logic [1:0] a, logic [7:0] exp);
    busAddr = a; #1;
    check(req, busRdata, exp);
  endtask

  task automatic tReset;
    rdChk("R1 psel", 0, 8'h03); rdChk("R1 mode", 1, 8'h00);
    rdChk("R1 clk", 2, 8'h00);  rdChk("R1 prot", 3, 8'h00);
    waitReq = 1; #1; check("R1 waitGrant", {7'b0, waitGrant}, 8'h01);
    check("R9 grant unlocked", {7'b0, waitGrant}, 8'h01);
    waitReq = 0;
  endtask

  task automatic tProt;
    wr(3, 8'hFF); rdChk("R10 prot bits", 3, 8'h07);
    wr(3, 8'h00); rdChk("R10 prot clear", 3, 8'h00);
  endtask

  task automatic tPsel;
    wr(0, 8'h00); rdChk("R2 blocked", 0, 8'h03);
    wr(3, 8'h01); wr(0, 8'hFE); rdChk("R2 write", 0, 8'h02);
    check("R2 timer", {7'b0, timerClkFull}, 8'h00);
    check("R2 serial", {7'b0, serClkFull}, 8'h01);
  endtask

  task automatic tMode;
    wr(3, 8'h00); wr(1, 8'h01); rdChk("R3 blocked", 1, 8'h00);
    wr(3, 8'h02); wr(1, 8'hF9); rdChk("R3 reserved zero", 1, 8'h01);
    check("R8 sfrOneWait", {7'b0, sfrOneWait}, 8'h01);
  endtask

  task automatic tClkPll;
    wr(3, 8'h00); wr(2, 8'hFF); rdChk("R4 blocked", 2, 8'h00);
    wr(3, 8'h06); wr(2, 8'h10); rdChk("R4 write", 2, 8'h10);
    check("R4 pllEn", {7'b0, pllEn}, 8'h01);
    wr(1, 8'h00); rdChk("R8 held with pll", 1, 8'h01);
    wr(2, 8'h00); wr(1, 8'h00); rdChk("R8 changed pll off", 1, 8'h00);
  endtask

  task automatic tWdtLock;
    wr(2, 8'h04); check("R7 stop before lock", {7'b0, stopReq}, 8'h01);
    wr(1, 8'h04); rdChk("R5 wdt set", 1, 8'h04);
    check("R7 outputs", {5'b0, wdtSrcOsc, ocoEnable, wdtRunInIdle}, 8'h07);
    wr(2, 8'h00); wr(2, 8'h04); rdChk("R7 stop ignored", 2, 8'h00);
    wr(1, 8'h00); rdChk("R5 wdt sticky", 1, 8'h04);
  endtask

  task automatic tSysLock;
    wr(2, 8'h6B); wr(1, 8'h02); rdChk("R5 sys set", 1, 8'h06);
    waitReq = 1; #1; check("R9 grant locked", {7'b0, waitGrant}, 8'h00); waitReq = 0;
    wr(2, 8'h80); rdChk("R6 partial write", 2, 8'hEB);
    wr(1, 8'h00); rdChk("R5 sys sticky", 1, 8'h06);
  endtask

  task automatic tResetClears;
    @(negedge clk); rstN = 0; #2; rstN = 1;
    rdChk("R5 reset clears", 1, 8'h00); rdChk("R1 clk after reset", 2, 8'h00);
  endtask

  initial begin
    #1; check("R1 reset wdt", {7'b0, wdtSrcOsc}, 8'h00);
    repeat (2) @(negedge clk); rstN = 1;
    tReset; tProt; tPsel; tMode; tClkPll; tWdtLock; tSysLock; tResetClears;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #100000;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule